// File: doc/BRIEF.md
# Standby Wake Timer

This block wakes a power-managed system after it has spent a programmed time in its light-sleep state. Software programs a 16-bit configuration word that holds a 4-bit timeout count and a one-bit resolution select. A rising edge on the sleep-state indication arms the timer. The timer then counts ticks of either one minute or thirty-two minutes. When the programmed number of ticks has elapsed, it emits a wake pulse.

A prescaler divides the base clock into one-minute ticks. The number of base-clock cycles per minute is a parameter, so a short minute can be used when testing. The timer latches the count and the resolution at the moment sleep is entered. Leaving sleep early stops the timer without a wake pulse and discards all partial progress. A zero count leaves the timer dormant.

Top module: `standby_wake_timer`

## Requirements
- R1: After reset, the register reads 16'h0000 and `wakePulse` is low.
- R2: A write stores the timeout count in bits 15:12 and the resolution select in bit 11, and a read returns them in the same positions. Bits 10:0 always read as zero, and writing them has no effect.
- R3: With select 0, the timer counts from the first clock edge at which `sleepActive` is sampled high after being low. `wakePulse` is then high in the cycle that follows edge number count × CYCLES_PER_MINUTE after that entry edge.
- R4: With select 1, each tick lasts 32 minutes, so the wake pulse follows count × 32 × CYCLES_PER_MINUTE edges after the entry edge.
- R5: If the count is zero when sleep is entered, no wake pulse is produced for as long as sleep lasts.
- R6: The count and the select are latched at sleep entry. Register writes made while the timer runs do not change the current timeout.
- R7: If `sleepActive` drops before the timeout, no wake pulse is produced, and the prescaler and the tick count are cleared. A later entry then times the full programmed interval again.
- R8: The wake pulse lasts exactly one cycle. No further pulse occurs until sleep is left and entered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Configuration register write strobe |
| regWrData | input | 16 | Configuration write data |
| regRdData | output | 16 | Configuration read data |
| sleepActive | input | 1 | High while the system is in light sleep |
| wakePulse | output | 1 | One-cycle wake event |

## Verification
The hardest situation to reach is one where the latched configuration differs from the live register while a timeout is running. The stimulus creates it by rewriting the register a few cycles after sleep entry. It then checks that the wake arrives at the time set by the old value. Early exit gets the same kind of treatment: sleep is dropped partway through an interval and then re-entered, and the full interval is measured again. This shows that stale prescaler and tick state was discarded. A short minute makes it possible to sweep every count with both resolutions, timing each wake to the exact cycle.

// File: rtl/standby_wake_pkg.sv
package standby_wake_pkg;

  localparam int COUNT_W = 4;
  localparam int SLOW_DIV = 32;
  localparam int SUB_W = $clog2(SLOW_DIV);

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } timerState_t;

  typedef struct packed {
    logic capture;
    logic clearCnt;
    logic runEn;
  } ctrlStrobes_t;

  typedef struct packed {
    logic finalTick;
    logic countZero;
  } dpStatus_t;

endpackage

// File: rtl/standby_wake_dp.sv
module standby_wake_dp
  import standby_wake_pkg::*;
#(
  parameter longint unsigned CYCLES_PER_MINUTE = 64'd6000000000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [15:0]   regWrData,
  output logic [15:0]   regRdData,
  input  ctrlStrobes_t  strobes,
  output dpStatus_t     status
);

  localparam int PRE_W = (CYCLES_PER_MINUTE > 64'd1) ? $clog2(CYCLES_PER_MINUTE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYCLES_PER_MINUTE - 64'd1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SLOW_DIV - 1);

  logic [COUNT_W-1:0] cfgCount;
  logic               cfgSlow;
  logic [COUNT_W-1:0] capCount;
  logic               capSlow;
  logic [PRE_W-1:0]   prescaleQ;
  logic [SUB_W-1:0]   subQ;
  logic [COUNT_W-1:0] tickQ;
  logic               minuteTick;
  logic               rateTick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgCount <= '0;
      cfgSlow  <= 1'b0;
    end else if (regWrEn) begin
      cfgCount <= regWrData[15:12];
      cfgSlow  <= regWrData[11];
    end
  end

  assign regRdData = {cfgCount, cfgSlow, 11'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capCount <= '0;
      capSlow  <= 1'b0;
    end else if (strobes.capture) begin
      capCount <= cfgCount;
      capSlow  <= cfgSlow;
    end
  end

  assign minuteTick = strobes.runEn && (prescaleQ == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearCnt) begin
      prescaleQ <= '0;
    end else if (strobes.runEn) begin
      prescaleQ <= (prescaleQ == PRE_LAST) ? '0 : prescaleQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearCnt) begin
      subQ <= '0;
    end else if (minuteTick && capSlow) begin
      subQ <= (subQ == SUB_LAST) ? '0 : subQ + 1'b1;
    end
  end

  assign rateTick = minuteTick && (!capSlow || (subQ == SUB_LAST));

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearCnt) begin
      tickQ <= '0;
    end else if (rateTick) begin
      tickQ <= tickQ + 1'b1;
    end
  end

  assign status.finalTick = rateTick && (tickQ == capCount - 1'b1);
  assign status.countZero = (cfgCount == '0);

  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    prescaleQ <= PRE_LAST);  // R3
  AST_TICK_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    strobes.runEn |-> (tickQ < capCount));  // R3
  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.runEn && $past(strobes.runEn)) |-> ($stable(capCount) && $stable(capSlow)));  // R6
  AST_CLEARED_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.clearCnt) |-> (prescaleQ == '0 && tickQ == '0 && subQ == '0));  // R7

endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl
  import standby_wake_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          sleepActive,
  input  dpStatus_t     status,
  output ctrlStrobes_t  strobes,
  output logic          wakePulse
);

  timerState_t stateQ;
  timerState_t stateD;
  logic        sleepPrev;
  logic        sleepEntry;
  logic        wakeD;

  assign sleepEntry = sleepActive && !sleepPrev;

  always_ff @(posedge clk) begin
    if (!rstN) sleepPrev <= 1'b0;
    else       sleepPrev <= sleepActive;
  end

  always_comb begin
    stateD           = stateQ;
    strobes.capture  = 1'b0;
    strobes.clearCnt = 1'b0;
    strobes.runEn    = 1'b0;
    wakeD            = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        strobes.clearCnt = 1'b1;
        if (sleepEntry && !status.countZero) begin
          strobes.capture = 1'b1;
          stateD          = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!sleepActive) begin
          strobes.clearCnt = 1'b1;
          stateD           = ST_IDLE;
        end else begin
          strobes.runEn = 1'b1;
          if (status.finalTick) begin
            wakeD  = 1'b1;
            stateD = ST_IDLE;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      wakePulse <= 1'b0;
    end else begin
      stateQ    <= stateD;
      wakePulse <= wakeD;
    end
  end

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);  // R8
  AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> $past(sleepActive));  // R7
  AST_ZERO_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && sleepEntry && status.countZero) |=> (stateQ == ST_IDLE));  // R5
  AST_IDLE_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (stateQ == ST_IDLE));  // R8

endmodule

// File: rtl/standby_wake_timer.sv
module standby_wake_timer
  import standby_wake_pkg::*;
#(
  parameter longint unsigned CYCLES_PER_MINUTE = 64'd6000000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  input  logic        sleepActive,
  output logic        wakePulse
);

  ctrlStrobes_t strobes;
  dpStatus_t    status;

  standby_wake_dp #(
    .CYCLES_PER_MINUTE(CYCLES_PER_MINUTE)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strobes   (strobes),
    .status    (status)
  );

  standby_wake_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .sleepActive (sleepActive),
    .status      (status),
    .strobes     (strobes),
    .wakePulse   (wakePulse)
  );

  AST_RESERVED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[10:0] == 11'b0);  // R2

endmodule

// File: tb/standby_wake_timer_test.sv
module standby_wake_timer_test;

  localparam int CPM = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        sleepActive = 1'b0;
  logic        wakePulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  standby_wake_timer #(.CYCLES_PER_MINUTE(64'(CPM))) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .sleepActive(sleepActive), .wakePulse(wakePulse)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic leaveSleep();
    @(negedge clk);
    sleepActive = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Enter sleep and watch a window; report first wake cycle and pulse count.
  task automatic watchSleep(input int window, output int firstAt, output int pulses);
    @(negedge clk);
    sleepActive = 1'b1;
    firstAt = -1;
    pulses = 0;
    for (int n = 1; n <= window; n++) begin
      @(negedge clk);
      if (wakePulse) begin
        pulses++;
        if (firstAt < 0) firstAt = n;
      end
    end
  endtask

  initial begin
    int firstAt;
    int pulses;
    repeat (3) @(negedge clk);
    check(regRdData == 16'h0000, "R1 reset read", int'(regRdData), 0);
    check(wakePulse == 1'b0, "R1 reset wake", int'(wakePulse), 0);
    rstN = 1'b1;
    @(negedge clk);

    writeReg(16'hFFFF);
    check(regRdData == 16'hF800, "R2 reserved bits", int'(regRdData), 16'hF800);
    writeReg(16'h07FF);
    check(regRdData == 16'h0000, "R2 reserved write ignored", int'(regRdData), 0);

    for (int s = 0; s < 2; s++) begin
      for (int c = 1; c < 16; c++) begin
        int t;
        t = c * CPM * (s == 1 ? 32 : 1);
        writeReg(16'((c << 12) | (s << 11)));
        check(regRdData == 16'((c << 12) | (s << 11)), "R2 readback",
              int'(regRdData), (c << 12) | (s << 11));
        watchSleep(t + 40, firstAt, pulses);
        if (s == 0) check(firstAt == t + 1, "R3 fast timeout cycle", firstAt, t + 1);
        else        check(firstAt == t + 1, "R4 slow timeout cycle", firstAt, t + 1);
        check(pulses == 1, "R8 single pulse", pulses, 1);
        leaveSleep();
      end
    end

    writeReg(16'h0000);
    watchSleep(300, firstAt, pulses);
    check(pulses == 0, "R5 zero count no wake", pulses, 0);
    leaveSleep();
    writeReg(16'h0800);
    watchSleep(300, firstAt, pulses);
    check(pulses == 0, "R5 zero count slow no wake", pulses, 0);
    leaveSleep();

    // R6: rewrite while running
    writeReg(16'h3000);
    @(negedge clk);
    sleepActive = 1'b1;
    firstAt = -1;
    pulses = 0;
    for (int n = 1; n <= 200; n++) begin
      @(negedge clk);
      if (n == 3) begin
        regWrEn = 1'b1;
        regWrData = 16'hF800;
      end else begin
        regWrEn = 1'b0;
      end
      if (wakePulse) begin
        pulses++;
        if (firstAt < 0) firstAt = n;
      end
    end
    check(firstAt == 3 * CPM + 1, "R6 latched timeout", firstAt, 3 * CPM + 1);
    check(pulses == 1, "R6 one pulse", pulses, 1);
    check(regRdData == 16'hF800, "R6 register updated", int'(regRdData), 16'hF800);
    leaveSleep();

    // R7: early exit, then full re-time
    writeReg(16'h5000);
    watchSleep(5 * CPM - 3, firstAt, pulses);
    check(pulses == 0, "R7 no wake before exit", pulses, 0);
    @(negedge clk);
    sleepActive = 1'b0;
    pulses = 0;
    for (int n = 0; n < 60; n++) begin
      @(negedge clk);
      if (wakePulse) pulses++;
    end
    check(pulses == 0, "R7 no wake after exit", pulses, 0);
    watchSleep(5 * CPM + 30, firstAt, pulses);
    check(firstAt == 5 * CPM + 1, "R7 full interval after re-entry", firstAt, 5 * CPM + 1);
    leaveSleep();

    // R7 slow: exit mid sub-count, re-entry
    writeReg(16'h1800);
    watchSleep(20 * CPM, firstAt, pulses);
    check(pulses == 0, "R7 slow partial no wake", pulses, 0);
    leaveSleep();
    watchSleep(32 * CPM + 30, firstAt, pulses);
    check(firstAt == 32 * CPM + 1, "R7 slow full interval", firstAt, 32 * CPM + 1);
    leaveSleep();

    // R8: long stay after wake
    writeReg(16'h2000);
    watchSleep(2 * CPM + 500, firstAt, pulses);
    check(pulses == 1, "R8 idle after wake", pulses, 1);
    leaveSleep();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule